// File: doc/BRIEF.md
# Run-Time Programmable I/Q CIC Decimator

This block sits in a receive chain right after the quadrature mixer. Each clock with `enable` high, it takes one in-phase sample and one quadrature sample. Both have already been moved to zero frequency. The block low-pass filters each channel with a four-stage cascaded integrator-comb filter and keeps one output per N inputs. It also produces the strobe that marks each decimated output.

The ratio N is set at run time through an addressed settings bus, which carries a write strobe, an address and a 32-bit data word. The stored field is zero-based: a value R gives N = R + 1. Software normally loads half of the total wanted decimation minus one, because a fixed decimate-by-two halfband stage follows this block.

Each output word is the comb result shifted right arithmetically by 4·ceil(log2 N) bits and then truncated to 16 bits. This removes the N^4 gain exactly when N is a power of two.

Top module: `iq_cic_decim`

## Requirements
- R1: A write with `cfgStb` high and `cfgAddr` equal to 33 loads `cfgData[6:0]` into the rate field R. Data bits 31..7 are discarded.
- R2: A write with any other address, or with `cfgStb` low, leaves R and the output cadence unchanged.
- R3: While enabled, `outValid` is high for single cycles, spaced exactly N = R + 1 clocks apart. With R = 0 it is high on every enabled cycle.
- R4: A rate write restarts decimation. The first `outValid` after the write comes exactly N clocks after the capturing edge, and integrator contents are kept.
- R5: When a constant input x is held, each output settles to floor(x·N^4 / 2^(4·ceil(log2 N))). This equals x when N is a power of two. Negative values round toward minus infinity.
- R6: The I and Q channels are filtered separately with identical behaviour, so different inputs give their own results.
- R7: While `enable` is low, `outValid` stays low and `outI`/`outQ` hold their values.
- R8: After synchronous reset, `outI`, `outQ` and `outValid` are zero and R is 3, which gives decimation by 4.
- R9: At the largest rate, R = 127 (N = 128), full-scale inputs of 32767 and -32768 come back unchanged without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one input sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Input sample valid / filter advance |
| cfgStb | input | 1 | Settings bus write strobe |
| cfgAddr | input | 8 | Settings bus register address |
| cfgData | input | 32 | Settings bus write data |
| inI | input | 16 | Signed in-phase input sample |
| inQ | input | 16 | Signed quadrature input sample |
| outI | output | 16 | Signed decimated in-phase output |
| outQ | output | 16 | Signed decimated quadrature output |
| outValid | output | 1 | One-cycle marker of a new decimated output |

## Verification
The main function is driven with constant I/Q levels held until the filter settles. Ratios are chosen in two groups. Power-of-two ratios (1, 2, 4, 16, 128) must return the input exactly, which exposes a wrong shift or a wrong stage count. Non-power-of-two ratios (3, 5, 7) leave a fractional gain, which exposes rounding and sign-handling faults, especially for negative levels. Giving I and Q opposite signs on every vector shows up any crossing or sharing between the channels. Further tests look at the gaps between output strobes after reset, after a register write, after ignored writes and during a long disable window; these show up faults in the counter reload and the restart.

// File: rtl/iq_cic_pkg.sv
package iq_cic_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic integEn; // advance integrators (input rate)
    logic combEn;  // advance combs and output register (decimated rate)
  } cicStrobes_t;
endpackage

// File: rtl/iq_cic_ctrl.sv
module iq_cic_ctrl
  import iq_cic_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RATE_W     = 7,
  parameter int STAGES     = 4,
  parameter logic [ADDR_W-1:0] RATE_ADDR  = 8'd33,
  parameter logic [RATE_W-1:0] RATE_RESET = 7'd3,
  localparam int SHIFT_W   = $clog2(STAGES * RATE_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               cfgStb,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [RATE_W-1:0]  cfgRate,
  output cicStrobes_t        strobes,
  output logic [RATE_W-1:0]  rateQ,
  output logic [SHIFT_W-1:0] shiftAmt
);
  logic [RATE_W-1:0] downCnt;
  logic rateWrite;

  assign rateWrite = cfgStb && (cfgAddr == RATE_ADDR);

  // Rate field and decimation down-counter
  always_ff @(posedge clk) begin
    if (rst) begin
      rateQ   <= RATE_RESET;
      downCnt <= RATE_RESET;
    end else if (rateWrite) begin
      rateQ   <= cfgRate;
      downCnt <= cfgRate;
    end else if (enable) begin
      downCnt <= (downCnt == '0) ? rateQ : downCnt - 1'b1;
    end
  end

  assign strobes.integEn = enable;
  assign strobes.combEn  = enable && (downCnt == '0) && !rateWrite;

  // Number of bits to drop: STAGES * ceil(log2(rate + 1))
  function automatic logic [SHIFT_W-1:0] gainShift(input logic [RATE_W-1:0] r);
    logic [RATE_W:0] n;
    int lg;
    n  = {1'b0, r} + 1'b1;
    lg = 0;
    for (int i = 0; i <= RATE_W; i++) begin
      if ((RATE_W+1)'(1) << i < n) lg = i + 1;
    end
    return SHIFT_W'(lg * STAGES);
  endfunction

  assign shiftAmt = gainShift(rateQ);
endmodule

// File: rtl/iq_cic_path.sv
module iq_cic_path
  import iq_cic_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RATE_W  = 7,
  parameter int STAGES  = 4,
  parameter int CHANS   = 2,
  parameter int SHIFT_W = 5,
  localparam int ACC_W  = DATA_W + STAGES * RATE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  cicStrobes_t                   strobes,
  input  logic [SHIFT_W-1:0]            shiftAmt,
  input  logic [CHANS-1:0][DATA_W-1:0]  sampleIn,
  output logic [CHANS-1:0][DATA_W-1:0]  sampleOut,
  output logic                          sampleValid
);
  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    logic signed [ACC_W-1:0] integ   [STAGES];
    logic signed [ACC_W-1:0] combDly [STAGES];
    logic signed [ACC_W-1:0] combVal [STAGES+1];
    logic signed [DATA_W-1:0] inSigned;

    assign inSigned = sampleIn[c];

    // Integrator cascade at input rate (wraps modulo 2^ACC_W)
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < STAGES; s++) integ[s] <= '0;
      end else if (strobes.integEn) begin
        integ[0] <= integ[0] + ACC_W'(inSigned);
        for (int s = 1; s < STAGES; s++) integ[s] <= integ[s] + integ[s-1];
      end
    end

    // Comb cascade at decimated rate, differential delay 1
    always_comb begin
      combVal[0] = integ[STAGES-1];
      for (int s = 0; s < STAGES; s++) combVal[s+1] = combVal[s] - combDly[s];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < STAGES; s++) combDly[s] <= '0;
        sampleOut[c] <= '0;
      end else if (strobes.combEn) begin
        for (int s = 0; s < STAGES; s++) combDly[s] <= combVal[s];
        sampleOut[c] <= DATA_W'(combVal[STAGES] >>> shiftAmt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sampleValid <= 1'b0;
    else     sampleValid <= strobes.combEn;
  end
endmodule

// File: rtl/iq_cic_decim.sv
module iq_cic_decim
  import iq_cic_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 32,
  parameter int RATE_W = 7,
  parameter int STAGES = 4,
  parameter logic [ADDR_W-1:0] RATE_ADDR  = 8'd33,
  parameter logic [RATE_W-1:0] RATE_RESET = 7'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfgStb,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [DATA_W-1:0] inI,
  input  logic [DATA_W-1:0] inQ,
  output logic [DATA_W-1:0] outI,
  output logic [DATA_W-1:0] outQ,
  output logic              outValid
);
  localparam int SHIFT_W = $clog2(STAGES * RATE_W + 1);

  cicStrobes_t strobes;
  logic [RATE_W-1:0]  rateQ;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [1:0][DATA_W-1:0] pathIn, pathOut;
  logic unusedCfgHigh;

  assign unusedCfgHigh = ^cfgData[CFG_W-1:RATE_W];

  iq_cic_ctrl #(
    .ADDR_W(ADDR_W), .RATE_W(RATE_W), .STAGES(STAGES),
    .RATE_ADDR(RATE_ADDR), .RATE_RESET(RATE_RESET)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable),
    .cfgStb(cfgStb), .cfgAddr(cfgAddr), .cfgRate(cfgData[RATE_W-1:0]),
    .strobes(strobes), .rateQ(rateQ), .shiftAmt(shiftAmt)
  );

  assign pathIn = {inQ, inI};

  iq_cic_path #(
    .DATA_W(DATA_W), .RATE_W(RATE_W), .STAGES(STAGES),
    .CHANS(2), .SHIFT_W(SHIFT_W)
  ) u_path (
    .clk(clk), .rst(rst), .strobes(strobes), .shiftAmt(shiftAmt),
    .sampleIn(pathIn), .sampleOut(pathOut), .sampleValid(outValid)
  );

  assign outI = pathOut[0];
  assign outQ = pathOut[1];
endmodule

// File: rtl/iq_cic_decim_chk.sv
module iq_cic_decim_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 32,
  parameter int RATE_W = 7,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 8'd33
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              cfgStb,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [CFG_W-1:0]  cfgData,
  input logic [DATA_W-1:0] outI,
  input logic [DATA_W-1:0] outQ,
  input logic              outValid,
  input logic [RATE_W-1:0] rateQ
);
  logic hit;
  assign hit = cfgStb && (cfgAddr == RATE_ADDR);

  // R1: addressed write loads the low data bits
  p_rate_load_r1: assert property (@(posedge clk) disable iff (rst)
    hit |=> rateQ == $past(cfgData[RATE_W-1:0]));

  // R2: anything else leaves the rate alone
  p_rate_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(rateQ));

  // R3: with a nonzero rate, output strobes are isolated pulses
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && rateQ != '0) |=> !outValid);

  // R4: a rate write cancels the strobe of that cycle
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !outValid);

  // R7: no output without an enabled cycle before it
  p_valid_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(enable));

  // R7: outputs move only together with the strobe
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outI) && $stable(outQ)));
endmodule

bind iq_cic_decim iq_cic_decim_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W),
  .RATE_W(RATE_W), .RATE_ADDR(RATE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .cfgStb(cfgStb),
  .cfgAddr(cfgAddr), .cfgData(cfgData), .outI(outI), .outQ(outQ),
  .outValid(outValid), .rateQ(rateQ)
);

// File: tb/iq_cic_decim_bench.sv
module iq_cic_decim_bench;
  localparam logic [7:0] RATE_ADDR = 8'd33;
  localparam int NVEC = 9;
  localparam int SETTLE = 12;

  // {rate, inI, inQ, expI, expQ}
  typedef struct packed {
    logic [6:0]         rate;
    logic signed [15:0] xi;
    logic signed [15:0] xq;
    logic signed [15:0] ei;
    logic signed [15:0] eq;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{7'd3,   16'sd1200,   -16'sd700,   16'sd1200,   -16'sd700},
    '{7'd1,   -16'sd15000, 16'sd9000,   -16'sd15000, 16'sd9000},
    '{7'd0,   16'sd32767,  -16'sd32768, 16'sd32767,  -16'sd32768},
    '{7'd2,   16'sd1000,   -16'sd1000,  16'sd316,    -16'sd317},
    '{7'd4,   16'sd1000,   -16'sd2000,  16'sd152,    -16'sd306},
    '{7'd6,   16'sd3000,   -16'sd1,     16'sd1758,   -16'sd1},
    '{7'd15,  16'sd12345,  -16'sd4321,  16'sd12345,  -16'sd4321},
    '{7'd127, 16'sd32767,  -16'sd32768, 16'sd32767,  -16'sd32768},
    '{7'd127, -16'sd32768, 16'sd32767,  -16'sd32768, 16'sd32767}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic cfgStb = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [15:0] inI = '0, inQ = '0;
  logic [15:0] outI, outQ;
  logic outValid;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  iq_cic_decim u_iq_cic_decim (
    .clk(clk), .rst(rst), .enable(enable), .cfgStb(cfgStb),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .inI(inI), .inQ(inQ),
    .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d, input logic stb);
    @(negedge clk);
    cfgStb = stb; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgStb = 1'b0; cfgAddr = '0; cfgData = '0;
  endtask

  task automatic waitValid();
    do @(negedge clk); while (!outValid);
  endtask

  // clocks from one strobe to the next
  task automatic measureGap(output int gap);
    waitValid();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!outValid);
  endtask

  // clocks from the capturing edge of a write to the first strobe
  task automatic measureRestart(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!outValid && k < 1000);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int gap;
    logic [15:0] heldI, heldQ;
    bit quiet;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check("R8 outI after reset", int'(outI), 0);
    check("R8 outQ after reset", int'(outQ), 0);
    check("R8 outValid after reset", int'(outValid), 0);
    enable = 1'b1;
    measureGap(gap);
    check("R8 reset rate gives period 4", gap, 4);

    // Vector table: DC levels per rate (R5, R6, R9)
    for (int v = 0; v < NVEC; v++) begin
      cfgWrite(RATE_ADDR, {25'd0, VECS[v].rate}, 1'b1);
      inI = VECS[v].xi; inQ = VECS[v].xq;
      for (int n = 0; n < SETTLE; n++) waitValid();
      check(VECS[v].rate == 7'd127 ? "R9 I full scale" : "R5 I dc level",
            int'($signed(outI)), int'(VECS[v].ei));
      check("R6 Q dc level", int'($signed(outQ)), int'(VECS[v].eq));
    end

    // R3: rate 0 gives a strobe every cycle
    cfgWrite(RATE_ADDR, 32'd0, 1'b1);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check("R3 rate 0 strobe every cycle", int'(outValid), 1);
    end

    // R3: period for rate 5
    cfgWrite(RATE_ADDR, 32'd5, 1'b1);
    measureGap(gap);
    check("R3 period rate 5", gap, 6);

    // R4: restart after a write, rate 9
    @(negedge clk);
    cfgStb = 1'b1; cfgAddr = RATE_ADDR; cfgData = 32'd9;
    @(negedge clk);
    cfgStb = 1'b0; cfgAddr = '0; cfgData = '0;
    measureRestart(gap);
    check("R4 first strobe after write", gap, 10);

    // R1: upper data bits discarded (0xFFFFFF83 -> rate 3)
    cfgWrite(RATE_ADDR, 32'hFFFF_FF83, 1'b1);
    measureGap(gap);
    check("R1 low seven bits captured", gap, 4);

    // R2: other address and missing strobe are ignored
    cfgWrite(8'd32, 32'd0, 1'b1);
    cfgWrite(RATE_ADDR, 32'd10, 1'b0);
    measureGap(gap);
    check("R2 ignored writes keep period", gap, 4);

    // R7: disabled for a while
    waitValid();
    @(negedge clk);
    enable = 1'b0;
    heldI = outI; heldQ = outQ;
    quiet = 1'b1;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (outValid || outI != heldI || outQ != heldQ) quiet = 1'b0;
    end
    check("R7 idle while disabled", int'(quiet), 1);
    enable = 1'b1;
    measureGap(gap);
    check("R7 period resumes", gap, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule